// File: doc/BRIEF.md
# Four-Channel PWM and Capture Timer

This block holds four independent timer channels. Each channel has one of three jobs. It can drive a pulse-width waveform forever, or it can emit a fixed number of periods and then stop. It can also time the high and low phases of an external input. Every channel has its own period, duty, repeat, control and status registers, all reached through one flat write/read port. A channel is chosen by the upper address bits and a register by the lower three bits.

In generator modes the output is high while the period counter is below the duty value and low for the rest of the period. Period and duty written while a channel runs are held in shadow registers and take effect only at the next period boundary. A one-shot run emits repeat + 1 periods and then raises its status bit once. In capture mode the input passes through a two-flop synchronizer. Each polarity change latches the length of the phase that just ended and raises the status bit. A static input decides whether the status bits leave on four separate interrupt lines or are merged onto one.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads 0, every `pwm_o` bit is low and every interrupt output is low.
- R2: With period P ≥ 1 and duty D, the output is high for the first min(D, P) cycles of every P-cycle period. The first period starts in the cycle after the edge that writes enable = 1. Period 0 behaves as 1.
- R3: Control mode 0 (continuous) runs without end and never sets the status bit. Mode value 3 behaves like mode 0.
- R4: Control mode 1 (one-shot) with repeat value N emits exactly N + 1 periods and then holds the output low. The status bit is set once, becoming visible after the edge that ends the last period.
- R5: Period and duty written while a channel runs apply only from the next period boundary. The period already in progress finishes with the old values.
- R6: Writing enable = 0 drives the output low in the very next cycle. A later enable restarts the waveform from the start of a period.
- R7: In capture mode (control mode 2), a change of the synchronized input latches the number of cycles the previous level lasted. A high phase goes to register 4 and a low phase to register 5. Both results are readable three clock edges after the input changes.
- R8: In capture mode every polarity change of the input sets the status bit. It becomes visible three edges after the input changes and not before.
- R9: The status bit (register 6, bit 0) is cleared by writing 1 to that bit. Writing 0 leaves it unchanged, and a new event in the same cycle wins over the clear.
- R10: When `irq_mode_i` = 0, `irq_ch_o[i]` is the status of channel i AND its interrupt enable, and `irq_all_o` is 0. When `irq_mode_i` = 1, `irq_ch_o` is 0 and `irq_all_o` is the OR of all enabled status bits.
- R11: A capture phase longer than the counter range is reported as the all-ones value; the counter never wraps.
- R12: The register map is addr = {channel, index}: 0 control ([0] enable, [2:1] mode, [3] interrupt enable), 1 period, 2 duty, 3 repeat, 4 high time, 5 low time, 6 status. Registers 0–3 read back what was written, and a write reaches only the addressed channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_mode_i | input | 1 | Static: 0 = one interrupt line per channel, 1 = single merged line |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | CH_W+3 | {channel, register index} |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| cap_i | input | NCH | Capture inputs, asynchronous |
| pwm_o | output | NCH | Waveform outputs |
| irq_ch_o | output | NCH | Per-channel interrupt lines |
| irq_all_o | output | 1 | Merged interrupt line |

## Verification
Register writes take effect at the edge that samples them, and reads are combinational. Generator output for cycle c of a run is therefore due after edge c, counting from the enable edge. A one-shot flag is due after edge (N+1)·P+1, and capture results and flags are due three edges after the input is driven. The bench drives inputs on falling edges and keeps a per-cycle history of the outputs, indexed by its own edge counter. It compares each recorded cycle against waveforms worked out arithmetically from P, D and N. The checks made at two and three edges after each capture toggle pin the synchronizer latency exactly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_CONT = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_CAP  = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } run_e;

  typedef struct packed {
    logic  irq_en;
    mode_e mode;
    logic  en;
  } ctrl_t;

  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_PER  = 3'd1;
  localparam logic [REG_AW-1:0] RA_DUTY = 3'd2;
  localparam logic [REG_AW-1:0] RA_REP  = 3'd3;
  localparam logic [REG_AW-1:0] RA_HIGH = 3'd4;
  localparam logic [REG_AW-1:0] RA_LOW  = 3'd5;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd6;
endpackage

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          oneshot_i,
  input  logic [DW-1:0] per_i,
  input  logic [DW-1:0] duty_i,
  input  logic [DW-1:0] rep_i,
  output logic          pwm_o,
  output logic          done_o
);
  localparam logic [DW-1:0] K_ONE  = DW'(1);
  localparam logic [DW:0]   K_ONEX = (DW+1)'(1);

  run_e          state_q;
  logic [DW-1:0] cnt_q, per_q, duty_q, rep_q;
  logic          wrap, last;

  assign wrap   = ({1'b0, cnt_q} + K_ONEX) >= {1'b0, per_q};
  assign last   = oneshot_i && (rep_q == '0);
  assign done_o = run_i && (state_q == ST_RUN) && wrap && last;
  assign pwm_o  = run_i && (state_q == ST_RUN) && (cnt_q < duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      rep_q   <= '0;
    end else if (!run_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          per_q   <= per_i;
          duty_q  <= duty_i;
          rep_q   <= rep_i;
        end
        ST_RUN: begin
          if (wrap) begin
            cnt_q <= '0;
            if (last) begin
              state_q <= ST_HALT;
            end else begin
              per_q  <= per_i;
              duty_q <= duty_i;
              if (oneshot_i) rep_q <= rep_q - K_ONE;
            end
          end else begin
            cnt_q <= cnt_q + K_ONE;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  // R2: counter stays inside the active period
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> ((cnt_q < per_q) || (per_q == '0)));

  // R5: active values only move at a boundary
  a_r5_hold_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && !wrap) |=> ($stable(per_q) && $stable(duty_q)));

  // R4: one completion, then silent output
  a_r4_one_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !pwm_o));
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cap_i,
  output logic [DW-1:0] high_o,
  output logic [DW-1:0] low_o,
  output logic          evt_o
);
  localparam logic [DW-1:0] K_ONE = DW'(1);
  localparam logic [DW-1:0] K_MAX = '1;

  logic [2:0]    sync_q;
  logic [DW-1:0] ph_q, high_q, low_q;
  logic          edge_w;

  assign edge_w = en_i && (sync_q[1] ^ sync_q[2]);
  assign evt_o  = edge_w;
  assign high_o = high_q;
  assign low_o  = low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], cap_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (!en_i) begin
      ph_q <= '0;
    end else if (edge_w) begin
      ph_q <= K_ONE;
      if (sync_q[1]) low_q  <= ph_q;
      else           high_q <= ph_q;
    end else if (ph_q != K_MAX) begin
      ph_q <= ph_q + K_ONE;
    end
  end

  // R11: phase counter saturates
  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !edge_w && (ph_q == K_MAX)) |=> (ph_q == K_MAX));

  // R7: a new phase begins counting at one
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w && en_i) |=> ((ph_q == K_ONE) || (ph_q == '0)));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              cap_i,
  output logic              pwm_o,
  output logic              stat_o,
  output logic              ie_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] per_q, duty_q, rep_q;
  logic [DW-1:0] high_w, low_w;
  logic          stat_q, gen_done, cap_evt, gen_run, cap_run, set_w, clr_w;

  assign gen_run = ctrl_q.en && (ctrl_q.mode != MODE_CAP);
  assign cap_run = ctrl_q.en && (ctrl_q.mode == MODE_CAP);
  assign set_w   = gen_done || cap_evt;
  assign clr_w   = wr_i && (reg_i == RA_STAT) && wdata_i[0];
  assign stat_o  = stat_q;
  assign ie_o    = ctrl_q.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
      rep_q  <= '0;
    end else if (wr_i) begin
      unique case (reg_i)
        RA_CTRL: ctrl_q <= ctrl_t'(wdata_i[3:0]);
        RA_PER:  per_q  <= wdata_i;
        RA_DUTY: duty_q <= wdata_i;
        RA_REP:  rep_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (set_w) stat_q <= 1'b1;
    else if (clr_w) stat_q <= 1'b0;
  end

  always_comb begin
    unique case (reg_i)
      RA_CTRL: rdata_o = {{(DW-4){1'b0}}, ctrl_q};
      RA_PER:  rdata_o = per_q;
      RA_DUTY: rdata_o = duty_q;
      RA_REP:  rdata_o = rep_q;
      RA_HIGH: rdata_o = high_w;
      RA_LOW:  rdata_o = low_w;
      RA_STAT: rdata_o = {{(DW-1){1'b0}}, stat_q};
      default: rdata_o = '0;
    endcase
  end

  pwm_gen #(.DW(DW)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (gen_run),
    .oneshot_i (ctrl_q.mode == MODE_ONE),
    .per_i     (per_q),
    .duty_i    (duty_q),
    .rep_i     (rep_q),
    .pwm_o     (pwm_o),
    .done_o    (gen_done)
  );

  pwm_capture #(.DW(DW)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_run),
    .cap_i  (cap_i),
    .high_o (high_w),
    .low_o  (low_w),
    .evt_o  (cap_evt)
  );

  // R3: only one-shot runs may complete
  a_r3_cont_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_done |-> (ctrl_q.mode == MODE_ONE));

  // R6: disabled channel drives low
  a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !pwm_o);

  // R8: every capture edge leaves the flag set
  a_r8_cap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> stat_q);

  // R9: write-one clears when no event competes
  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !set_w) |=> !stat_q);
endmodule

// File: rtl/pwm_irq_route.sv
module pwm_irq_route #(
  parameter int unsigned NCH = 4
) (
  input  logic           irq_mode_i,
  input  logic [NCH-1:0] stat_i,
  input  logic [NCH-1:0] ie_i,
  output logic [NCH-1:0] irq_ch_o,
  output logic           irq_all_o
);
  logic [NCH-1:0] pend;

  assign pend      = stat_i & ie_i;
  assign irq_ch_o  = irq_mode_i ? '0 : pend;
  assign irq_all_o = irq_mode_i & (|pend);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DW     = 16,
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned ADDR_W = CH_W + REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH-1:0]    cap_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    irq_ch_o,
  output logic              irq_all_o
);
  logic [CH_W-1:0]   ch_sel;
  logic [REG_AW-1:0] reg_sel;
  logic [NCH-1:0]    stat, ie;
  logic [DW-1:0]     rd_ch [NCH];

  assign ch_sel  = addr_i[ADDR_W-1:REG_AW];
  assign reg_sel = addr_i[REG_AW-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (ch_sel == CH_W'(g))),
      .reg_i   (reg_sel),
      .wdata_i (wdata_i),
      .rdata_o (rd_ch[g]),
      .cap_i   (cap_i[g]),
      .pwm_o   (pwm_o[g]),
      .stat_o  (stat[g]),
      .ie_o    (ie[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel == CH_W'(i)) rdata_o = rd_ch[i];
    end
  end

  pwm_irq_route #(.NCH(NCH)) u_irq (
    .irq_mode_i (irq_mode_i),
    .stat_i     (stat),
    .ie_i       (ie),
    .irq_ch_o   (irq_ch_o),
    .irq_all_o  (irq_all_o)
  );

  // R10: exactly one routing style is live
  a_r10_split_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mode_i |-> (irq_ch_o == '0));
  a_r10_join_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mode_i |-> !irq_all_o);
  a_r10_join_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_all_o |-> ($countones(stat) > 0));
endmodule

// File: tb/sim_pwm_multi.sv
module sim_pwm_multi;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int AW  = 5;
  localparam int HM  = 16383;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] cap = '0;
  logic [NCH-1:0] pwm, irq_ch;
  logic          irq_all;

  always #2 clk = ~clk;

  pwm_multi #(.NCH(NCH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_mode_i(irq_mode), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap),
    .pwm_o(pwm), .irq_ch_o(irq_ch), .irq_all_o(irq_all)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [NCH-1:0] h_pwm [HM+1];
  logic [NCH-1:0] h_irq [HM+1];
  always @(negedge clk) begin
    h_pwm[cyc & HM] <= pwm;
    h_irq[cyc & HM] <= irq_ch;
  end

  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int ch, input int r, input int d);
    addr  = AW'(ch * 8 + r);
    wdata = DW'(d);
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, output int v);
    addr = AW'(ch * 8 + r);
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit hp(input int idx, input int ch);
    return h_pwm[idx & HM][ch];
  endfunction

  function automatic bit hi(input int idx, input int ch);
    return h_irq[idx & HM][ch];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, e0, k;
    int hl[4], ll[4];
    hl = '{5, 8, 12, 20};
    ll = '{6, 9, 5, 17};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1: reset state
    chk(pwm == '0, "R1 pwm", pwm, 0);
    chk(irq_ch == '0 && !irq_all, "R1 irq", {irq_all, irq_ch}, 0);
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 7; r++) begin
        rd(c, r, v);
        chk(v == 0, "R1 reg", v, 0);
      end
    end

    // R12: readback and channel isolation
    wr(0, 1, 'h1234);
    wr(0, 2, 'h0056);
    wr(0, 3, 7);
    wr(0, 0, 8);
    rd(0, 1, v); chk(v == 'h1234, "R12 period", v, 'h1234);
    rd(0, 2, v); chk(v == 'h56, "R12 duty", v, 'h56);
    rd(0, 3, v); chk(v == 7, "R12 repeat", v, 7);
    rd(0, 0, v); chk(v == 8, "R12 ctrl", v, 8);
    rd(1, 1, v); chk(v == 0, "R12 isolation", v, 0);
    chk(pwm == '0, "R12 no run", pwm, 0);
    wr(0, 0, 0);

    // R2 R4: one-shot sweep over period, duty, repeat
    k = 0;
    for (int p = 1; p <= 4; p++) begin
      for (int d = 0; d <= 5; d++) begin
        for (int n = 0; n <= 2; n++) begin
          int ch, w, hcnt, first, late;
          ch = k % NCH;
          k++;
          wr(ch, 1, p);
          wr(ch, 2, d);
          wr(ch, 3, n);
          wr(ch, 0, 1 | (1 << 1) | (1 << 3));
          e0 = cyc;
          w = (n + 1) * p;
          wait_cyc(w + 4);
          hcnt = 0; first = -1; late = 0;
          for (int c = 1; c <= w + 3; c++) begin
            if (hp(e0 + c, ch)) begin
              if (c <= w) hcnt++;
              else late++;
            end
            if (hi(e0 + c, ch) && first < 0) first = c;
          end
          chk(hcnt == (n + 1) * ((d < p) ? d : p), "R2 high cycles", hcnt, (n + 1) * ((d < p) ? d : p));
          chk(late == 0, "R4 halted low", late, 0);
          chk(first == w + 1, "R4 flag cycle", first, w + 1);
          chk(irq_ch[ch] == 1'b1, "R4 flag held", irq_ch[ch], 1);
          wr(ch, 6, 1);
          chk(irq_ch[ch] == 1'b0, "R9 clear", irq_ch[ch], 0);
          wr(ch, 0, 0);
        end
      end
    end

    // R3 R5: continuous with mid-run update
    wr(2, 1, 8);
    wr(2, 2, 2);
    wr(2, 0, 1 | (1 << 3));
    e0 = cyc;
    wr(2, 1, 3);
    wr(2, 2, 1);
    wait_cyc(30);
    for (int c = 1; c <= 28; c++) begin
      bit ex;
      ex = (c <= 8) ? ((c - 1) < 2) : (((c - 9) % 3) < 1);
      chk(hp(e0 + c, 2) == ex, "R5 waveform", hp(e0 + c, 2), ex);
      chk(hi(e0 + c, 2) == 1'b0, "R3 no irq", hi(e0 + c, 2), 0);
    end
    rd(2, 6, v); chk(v == 0, "R3 status", v, 0);
    wr(2, 0, 0);

    // R6: immediate stop and clean restart
    wr(1, 1, 5);
    wr(1, 2, 5);
    wr(1, 0, 1);
    wait_cyc(4);
    chk(pwm[1] == 1'b1, "R6 running", pwm[1], 1);
    wr(1, 0, 0);
    chk(pwm[1] == 1'b0, "R6 stop", pwm[1], 0);
    wr(1, 2, 2);
    wr(1, 0, 1);
    e0 = cyc;
    wait_cyc(8);
    for (int c = 1; c <= 6; c++) begin
      bit ex;
      ex = ((c - 1) % 5) < 2;
      chk(hp(e0 + c, 1) == ex, "R6 restart", hp(e0 + c, 1), ex);
    end
    wr(1, 0, 0);

    // R7 R8 R9: capture phases on channel 3
    wr(3, 0, 1 | (2 << 1) | (1 << 3));
    wait_cyc(4);
    for (int i = 0; i < 4; i++) begin
      cap[3] = 1'b1;
      wait_cyc(2);
      chk(irq_ch[3] == 1'b0, "R8 early rise", irq_ch[3], 0);
      wait_cyc(1);
      chk(irq_ch[3] == 1'b1, "R8 rise flag", irq_ch[3], 1);
      if (i > 0) begin
        rd(3, 5, v); chk(v == ll[i-1], "R7 low time", v, ll[i-1]);
      end
      wr(3, 6, 1);
      chk(irq_ch[3] == 1'b0, "R9 clear", irq_ch[3], 0);
      wait_cyc(hl[i] - 4);
      cap[3] = 1'b0;
      wait_cyc(2);
      chk(irq_ch[3] == 1'b0, "R8 early fall", irq_ch[3], 0);
      wait_cyc(1);
      chk(irq_ch[3] == 1'b1, "R8 fall flag", irq_ch[3], 1);
      rd(3, 4, v); chk(v == hl[i], "R7 high time", v, hl[i]);
      wr(3, 6, 1);
      wait_cyc(ll[i] - 4);
    end
    cap[3] = 1'b1;
    wait_cyc(3);
    rd(3, 5, v); chk(v == ll[3], "R7 low time", v, ll[3]);
    wr(3, 6, 1);

    // R11: saturation, R9 write of 0
    cap[3] = 1'b0;
    wait_cyc(3);
    wr(3, 6, 0);
    chk(irq_ch[3] == 1'b1, "R9 write zero keeps", irq_ch[3], 1);
    wr(3, 6, 1);
    wait_cyc(70000);
    cap[3] = 1'b1;
    wait_cyc(3);
    rd(3, 5, v); chk(v == 65535, "R11 saturate", v, 65535);

    // R10: interrupt routing
    irq_mode = 1'b1;
    wait_cyc(1);
    chk(irq_ch == '0, "R10 merged split off", irq_ch, 0);
    chk(irq_all == 1'b1, "R10 merged on", irq_all, 1);
    wr(3, 0, 1 | (2 << 1));
    chk(irq_all == 1'b0, "R10 merged masked", irq_all, 0);
    irq_mode = 1'b0;
    wait_cyc(1);
    chk(irq_ch[3] == 1'b0, "R10 split masked", irq_ch[3], 0);
    wr(3, 0, 1 | (2 << 1) | (1 << 3));
    chk(irq_ch[3] == 1'b1 && !irq_all, "R10 split on", {irq_all, irq_ch[3]}, 1);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule